// File: doc/BRIEF.md
# Accumulator Machine Micro-Step Sequencer

This block is the control unit of a small 8-bit accumulator machine built around one shared data bus. After each instruction fetch it reads the opcode held in the instruction register's upper nibble. It then walks a fixed list of micro-steps for that opcode. In every clock it raises the control lines for one register transfer across the bus, plus any side actions that step needs: memory read or write, program-counter increment, or the ALU's add or subtract selection.

The datapath registers, the ALU and the memory are outside the block. The surrounding datapath supplies the live opcode, the ALU carry flag and a zero flag for the accumulator. All control outputs are decoded combinationally from the registered step number and the live opcode. A halt instruction freezes the sequencer until the asynchronous reset is asserted.

Top module: `acc_useq`

## Requirements
- R1: While `rst_ni` is low the sequencer sits at fetch step 0 with `halt_o` low. Assertion of `rst_ni` takes effect at once, with no clock edge, including mid-instruction and in the halt state.
- R2: Every instruction starts with four fetch steps. Step 0 moves the program counter into the memory address register. Step 1 raises `mem_rd_o` only. Step 2 moves the memory data register into the instruction register. Step 3 raises `pc_inc_o` only. `opcode_i` has no effect on these steps.
- R3: The opcode field is 4 bits: 0 no-op, 1 load, 2 add, 3 subtract, 4 store, 5 load immediate, 6 jump, 7 jump on carry, 8 jump on zero, 14 output, 15 halt. Opcodes 0 and 9 to 13 end the instruction after fetch step 3, so the instruction lasts 4 cycles.
- R4: Load (1) runs operand→MAR, then a memory read, then MDR→A, for 7 cycles in total.
- R5: Add (2) and subtract (3) run operand→MAR, a memory read, MDR→B, an ALU-select step, then ALU→A. This takes 9 cycles. `alu_add_o` (add) or `alu_sub_o` (subtract) is high in the last two steps only.
- R6: Store (4) runs operand→MAR, then A→MDR, then a step that raises `mem_wr_o` only, for 7 cycles.
- R7: Load immediate (5), jump (6) and output (14) each add one step: operand→A, operand→PC and A→output register respectively.
- R8: Jump on carry (7) and jump on zero (8) add one step. That step carries operand→PC only when `carry_i` (for 7) or `zero_i` (for 8) is high in it. Otherwise no line is raised in that step.
- R9: Halt (15) adds one step that raises only `halt_o`. From then on `halt_o` stays high and every other output stays low until reset, whatever `opcode_i`, `carry_i` and `zero_i` do.
- R10: Sources on `bus_src_o` are bit 0 PC, bit 1 MDR, bit 2 operand, bit 3 A and bit 4 ALU. Destinations on `bus_dst_o` are bit 0 MAR, bit 1 IR, bit 2 B, bit 3 A, bit 4 PC, bit 5 MDR and bit 6 output register. At most one bit of each is high. A destination is high exactly when a source is high. `mem_rd_o` and `mem_wr_o` are never high together.
- R11: The cycle after an instruction's final step is fetch step 0 of the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Upper nibble of the instruction register |
| carry_i | input | 1 | ALU carry flag |
| zero_i | input | 1 | Accumulator-is-zero flag |
| bus_src_o | output | 5 | One-hot bus driver enable |
| bus_dst_o | output | 7 | One-hot bus load enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| pc_inc_o | output | 1 | Program-counter increment |
| alu_add_o | output | 1 | ALU add select |
| alu_sub_o | output | 1 | ALU subtract select |
| halt_o | output | 1 | Halt indication |

## Verification
The assertions check on every cycle the rules that do not depend on the opcode's sequence:
- one-hot source and destination, paired with each other;
- read and write never together;
- a jump into PC only when its flag is set;
- an ALU source only with exactly one ALU select;
- a return to step 0 after a final step;
- the sticky, quiet halt state.

Only the bench's scenarios can show that each opcode yields its exact ordered list of transfers and its exact length. The same holds for the no-op opcodes, for the taken and not-taken forms of both jumps, and for asynchronous reset taking effect mid-instruction and from halt.

// File: rtl/acc_useq_pkg.sv
package acc_useq_pkg;

  localparam int unsigned OP_W    = 4;
  localparam int unsigned SRC_N   = 5;
  localparam int unsigned DST_N   = 7;
  localparam int unsigned FETCH_N = 4;
  localparam int unsigned EXEC_MAX = 5;
  localparam int unsigned STEP_MAX = FETCH_N + EXEC_MAX - 1;

  // bus sources
  localparam int unsigned SRC_PC  = 0;
  localparam int unsigned SRC_MDR = 1;
  localparam int unsigned SRC_OPR = 2;
  localparam int unsigned SRC_ACC = 3;
  localparam int unsigned SRC_ALU = 4;

  // bus destinations
  localparam int unsigned DST_MAR = 0;
  localparam int unsigned DST_IR  = 1;
  localparam int unsigned DST_B   = 2;
  localparam int unsigned DST_ACC = 3;
  localparam int unsigned DST_PC  = 4;
  localparam int unsigned DST_MDR = 5;
  localparam int unsigned DST_OUT = 6;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,
    OP_LDA = 4'd1,
    OP_ADD = 4'd2,
    OP_SUB = 4'd3,
    OP_STA = 4'd4,
    OP_LDI = 4'd5,
    OP_JMP = 4'd6,
    OP_JC  = 4'd7,
    OP_JZ  = 4'd8,
    OP_OUT = 4'd14,
    OP_HLT = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    COND_NONE = 2'd0,
    COND_C    = 2'd1,
    COND_Z    = 2'd2
  } cond_e;

  typedef struct packed {
    logic [SRC_N-1:0] src;
    logic [DST_N-1:0] dst;
    logic             rd;
    logic             wr;
    logic             inc;
    logic             add;
    logic             sub;
    logic             hlt;
    logic             last;
    cond_e            cond;
  } uword_t;

  function automatic logic is_noop(logic [OP_W-1:0] op);
    return (op == OP_NOP) || (op >= 4'd9 && op <= 4'd13);
  endfunction

  function automatic uword_t xfer(int unsigned s, int unsigned d);
    uword_t w;
    w = '0;
    w.src = SRC_N'(1) << s;
    w.dst = DST_N'(1) << d;
    return w;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import acc_useq_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [STEP_W-1:0] step_i,
  output uword_t            word_o
);

  int unsigned st;
  int unsigned ex;

  always_comb begin
    word_o = '0;
    st     = int'(step_i);
    ex     = st - FETCH_N;
    if (st < FETCH_N) begin
      case (st)
        0:       word_o = xfer(SRC_PC, DST_MAR);
        1:       word_o.rd = 1'b1;
        2:       word_o = xfer(SRC_MDR, DST_IR);
        default: begin
          word_o.inc  = 1'b1;
          word_o.last = is_noop(op_i);
        end
      endcase
    end else begin
      case (op_e'(op_i))
        OP_LDA: begin
          case (ex)
            0:       word_o = xfer(SRC_OPR, DST_MAR);
            1:       word_o.rd = 1'b1;
            default: begin
              word_o      = xfer(SRC_MDR, DST_ACC);
              word_o.last = 1'b1;
            end
          endcase
        end
        OP_ADD, OP_SUB: begin
          case (ex)
            0:       word_o = xfer(SRC_OPR, DST_MAR);
            1:       word_o.rd = 1'b1;
            2:       word_o = xfer(SRC_MDR, DST_B);
            3: begin
              word_o.add = (op_i == OP_ADD);
              word_o.sub = (op_i == OP_SUB);
            end
            default: begin
              word_o      = xfer(SRC_ALU, DST_ACC);
              word_o.add  = (op_i == OP_ADD);
              word_o.sub  = (op_i == OP_SUB);
              word_o.last = 1'b1;
            end
          endcase
        end
        OP_STA: begin
          case (ex)
            0:       word_o = xfer(SRC_OPR, DST_MAR);
            1:       word_o = xfer(SRC_ACC, DST_MDR);
            default: begin
              word_o.wr   = 1'b1;
              word_o.last = 1'b1;
            end
          endcase
        end
        OP_LDI: begin
          word_o      = xfer(SRC_OPR, DST_ACC);
          word_o.last = 1'b1;
        end
        OP_JMP: begin
          word_o      = xfer(SRC_OPR, DST_PC);
          word_o.last = 1'b1;
        end
        OP_JC: begin
          word_o      = xfer(SRC_OPR, DST_PC);
          word_o.cond = COND_C;
          word_o.last = 1'b1;
        end
        OP_JZ: begin
          word_o      = xfer(SRC_OPR, DST_PC);
          word_o.cond = COND_Z;
          word_o.last = 1'b1;
        end
        OP_OUT: begin
          word_o      = xfer(SRC_ACC, DST_OUT);
          word_o.last = 1'b1;
        end
        OP_HLT:  word_o.hlt = 1'b1;
        default: word_o.last = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import acc_useq_pkg::*;
(
  input  uword_t word_i,
  input  logic   carry_i,
  input  logic   zero_i,
  output uword_t word_o
);

  logic pass;

  always_comb begin
    case (word_i.cond)
      COND_C:  pass = carry_i;
      COND_Z:  pass = zero_i;
      default: pass = 1'b1;
    endcase
    word_o = word_i;
    if (!pass) begin
      word_o.src = '0;
      word_o.dst = '0;
    end
  end

endmodule

// File: rtl/useq_step.sv
module useq_step
  import acc_useq_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              halt_i,
  output logic [STEP_W-1:0] step_o,
  output logic              halted_o
);

  logic [STEP_W-1:0] step_q;
  logic              halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (halt_i)      halted_q <= 1'b1;
      else if (last_i) step_q   <= '0;
      else             step_q   <= step_q + 1'b1;
    end
  end

  assign step_o   = step_q;
  assign halted_o = halted_q;

  AST_WRAP_TO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && !halt_i && !halted_q) |=> (step_q == '0)); // R11
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && $stable(step_q))); // R9
  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(step_q) <= STEP_MAX)); // R11

endmodule

// File: rtl/acc_useq.sv
module acc_useq
  import acc_useq_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic             carry_i,
  input  logic             zero_i,
  output logic [SRC_N-1:0] bus_src_o,
  output logic [DST_N-1:0] bus_dst_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             pc_inc_o,
  output logic             alu_add_o,
  output logic             alu_sub_o,
  output logic             halt_o
);

  uword_t            rom_w;
  uword_t            cond_w;
  logic [STEP_W-1:0] step;
  logic              halted;

  useq_rom #(.STEP_W(STEP_W)) u_rom (
    .op_i   (opcode_i),
    .step_i (step),
    .word_o (rom_w)
  );

  useq_cond u_cond (
    .word_i  (rom_w),
    .carry_i (carry_i),
    .zero_i  (zero_i),
    .word_o  (cond_w)
  );

  useq_step #(.STEP_W(STEP_W)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .last_i   (cond_w.last),
    .halt_i   (cond_w.hlt),
    .step_o   (step),
    .halted_o (halted)
  );

  // halt state silences every control line
  assign bus_src_o = halted ? '0 : cond_w.src;
  assign bus_dst_o = halted ? '0 : cond_w.dst;
  assign mem_rd_o  = !halted && cond_w.rd;
  assign mem_wr_o  = !halted && cond_w.wr;
  assign pc_inc_o  = !halted && cond_w.inc;
  assign alu_add_o = !halted && cond_w.add;
  assign alu_sub_o = !halted && cond_w.sub;
  assign halt_o    = halted || cond_w.hlt;

  AST_SRC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_src_o)); // R10
  AST_DST_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_dst_o)); // R10
  AST_XFER_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_src_o != '0) == (bus_dst_o != '0))); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R10
  AST_JC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_JC && bus_dst_o[DST_PC]) |-> carry_i); // R8
  AST_JZ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_JZ && bus_dst_o[DST_PC]) |-> zero_i); // R8
  AST_COND_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_w.cond != COND_NONE) |-> (opcode_i == OP_JC || opcode_i == OP_JZ)); // R8
  AST_ALU_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_src_o[SRC_ALU] |-> (alu_add_o ^ alu_sub_o)); // R5
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && bus_src_o == '0 && bus_dst_o == '0 && !mem_rd_o &&
                !mem_wr_o && !pc_inc_o && !alu_add_o && !alu_sub_o)); // R9

endmodule

// File: tb/sim_acc_useq.sv
`timescale 1ns/1ps
module sim_acc_useq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opcode = 4'd0;
  logic       carry = 1'b0;
  logic       zero = 1'b0;
  logic [4:0] bus_src;
  logic [6:0] bus_dst;
  logic       mem_rd, mem_wr, pc_inc, alu_add, alu_sub, halt;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  acc_useq u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .opcode_i  (opcode),
    .carry_i   (carry),
    .zero_i    (zero),
    .bus_src_o (bus_src),
    .bus_dst_o (bus_dst),
    .mem_rd_o  (mem_rd),
    .mem_wr_o  (mem_wr),
    .pc_inc_o  (pc_inc),
    .alu_add_o (alu_add),
    .alu_sub_o (alu_sub),
    .halt_o    (halt)
  );

  // {op, carry, zero}
  localparam int N_VEC = 20;
  localparam logic [5:0] VEC [N_VEC] = '{
    {4'd0, 2'b00}, {4'd1, 2'b00}, {4'd2, 2'b10}, {4'd3, 2'b00},
    {4'd4, 2'b00}, {4'd5, 2'b00}, {4'd6, 2'b00}, {4'd7, 2'b10},
    {4'd7, 2'b00}, {4'd8, 2'b01}, {4'd8, 2'b00}, {4'd9, 2'b11},
    {4'd10, 2'b00}, {4'd11, 2'b01}, {4'd12, 2'b10}, {4'd13, 2'b00},
    {4'd14, 2'b00}, {4'd7, 2'b01}, {4'd8, 2'b10}, {4'd3, 2'b01}
  };

  localparam logic [4:0] S_PC = 5'h01, S_MDR = 5'h02, S_OPR = 5'h04, S_ACC = 5'h08, S_ALU = 5'h10;
  localparam logic [6:0] D_MAR = 7'h01, D_IR = 7'h02, D_B = 7'h04, D_ACC = 7'h08,
                         D_PC = 7'h10, D_MDR = 7'h20, D_OUT = 7'h40;
  localparam logic [17:0] W_HALT = 18'h1;

  function automatic logic [17:0] mk(logic [4:0] s, logic [6:0] d, logic rd, logic wr,
                                     logic inc, logic ad, logic sb, logic h);
    return {s, d, rd, wr, inc, ad, sb, h};
  endfunction

  function automatic int exp_len(logic [3:0] op);
    case (op)
      4'd1, 4'd4:                    return 7;
      4'd2, 4'd3:                    return 9;
      4'd5, 4'd6, 4'd7, 4'd8, 4'd14, 4'd15: return 5;
      default:                       return 4;
    endcase
  endfunction

  function automatic logic [17:0] exp_word(logic [3:0] op, logic c, logic z, int k);
    logic ad, sb;
    ad = (op == 4'd2);
    sb = (op == 4'd3);
    case (k)
      0: return mk(S_PC, D_MAR, 0, 0, 0, 0, 0, 0);
      1: return mk(5'h0, 7'h0, 1, 0, 0, 0, 0, 0);
      2: return mk(S_MDR, D_IR, 0, 0, 0, 0, 0, 0);
      3: return mk(5'h0, 7'h0, 0, 0, 1, 0, 0, 0);
      default: ;
    endcase
    case (op)
      4'd1: case (k - 4)
              0: return mk(S_OPR, D_MAR, 0, 0, 0, 0, 0, 0);
              1: return mk(5'h0, 7'h0, 1, 0, 0, 0, 0, 0);
              default: return mk(S_MDR, D_ACC, 0, 0, 0, 0, 0, 0);
            endcase
      4'd2, 4'd3: case (k - 4)
              0: return mk(S_OPR, D_MAR, 0, 0, 0, 0, 0, 0);
              1: return mk(5'h0, 7'h0, 1, 0, 0, 0, 0, 0);
              2: return mk(S_MDR, D_B, 0, 0, 0, 0, 0, 0);
              3: return mk(5'h0, 7'h0, 0, 0, 0, ad, sb, 0);
              default: return mk(S_ALU, D_ACC, 0, 0, 0, ad, sb, 0);
            endcase
      4'd4: case (k - 4)
              0: return mk(S_OPR, D_MAR, 0, 0, 0, 0, 0, 0);
              1: return mk(S_ACC, D_MDR, 0, 0, 0, 0, 0, 0);
              default: return mk(5'h0, 7'h0, 0, 1, 0, 0, 0, 0);
            endcase
      4'd5:  return mk(S_OPR, D_ACC, 0, 0, 0, 0, 0, 0);
      4'd6:  return mk(S_OPR, D_PC, 0, 0, 0, 0, 0, 0);
      4'd7:  return c ? mk(S_OPR, D_PC, 0, 0, 0, 0, 0, 0) : 18'h0;
      4'd8:  return z ? mk(S_OPR, D_PC, 0, 0, 0, 0, 0, 0) : 18'h0;
      4'd14: return mk(S_ACC, D_OUT, 0, 0, 0, 0, 0, 0);
      4'd15: return W_HALT;
      default: return 18'h0;
    endcase
  endfunction

  function automatic string req_tag(logic [3:0] op, int k);
    if (k == 0) return "R2 R11";
    if (k < 3)  return "R2";
    if (k == 3) return (exp_len(op) == 4) ? "R3" : "R2";
    case (op)
      4'd1:             return "R4";
      4'd2, 4'd3:       return "R5";
      4'd4:             return "R6";
      4'd5, 4'd6, 4'd14: return "R7";
      4'd7, 4'd8:       return "R8";
      default:          return "R9";
    endcase
  endfunction

  function automatic logic [17:0] actual();
    return {bus_src, bus_dst, mem_rd, mem_wr, pc_inc, alu_add, alu_sub, halt};
  endfunction

  task automatic check(string tag, logic [17:0] exp);
    n_chk++;
    if (actual() !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t got=%05h exp=%05h", tag, $time, actual(), exp);
    end
  endtask

  task automatic check_bus();
    logic ok;
    ok = ($countones(bus_src) <= 1) && ($countones(bus_dst) <= 1) &&
         ((bus_src != 0) == (bus_dst != 0)) && !(mem_rd && mem_wr);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R10 src=%b dst=%b rd=%b wr=%b exp=legal-encoding",
               bus_src, bus_dst, mem_rd, mem_wr);
    end
  endtask

  task automatic run_instr(logic [3:0] op, logic c, logic z);
    for (int k = 0; k < exp_len(op); k++) begin
      @(negedge clk);
      if (k == 0) begin
        opcode = op;
        carry  = c;
        zero   = z;
        #1;
      end
      check(req_tag(op, k), exp_word(op, c, z, k));
      check_bus();
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog got=running exp=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", exp_word(4'd0, 0, 0, 0));
    @(posedge clk);
    #1 rst_n = 1'b1;

    // table walk
    for (int i = 0; i < N_VEC; i++)
      run_instr(VEC[i][5:2], VEC[i][1], VEC[i][0]);

    // R9: halt freezes, inputs ignored
    run_instr(4'd15, 1'b0, 1'b0);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      opcode = 4'(j + 1);
      carry  = j[0];
      zero   = ~j[0];
      #1;
      check("R9", W_HALT);
    end

    // R1: async reset out of halt
    #1 rst_n = 1'b0;
    #1 check("R1", exp_word(4'd0, 0, 0, 0));
    @(posedge clk);
    #1 rst_n = 1'b1;
    run_instr(4'd5, 1'b0, 1'b0);

    // R1: async reset mid add
    @(negedge clk);
    opcode = 4'd2;
    #1 check("R2", exp_word(4'd2, 0, 0, 0));
    repeat (6) @(negedge clk);
    check("R5", exp_word(4'd2, 0, 0, 6));
    #1 rst_n = 1'b0;
    #1 check("R1", exp_word(4'd2, 0, 0, 0));
    @(posedge clk);
    #1 rst_n = 1'b1;
    run_instr(4'd6, 1'b0, 1'b0);
    run_instr(4'd3, 1'b1, 1'b1);

    finish_run();
  end

endmodule